// File: doc/BRIEF.md
# Table I/O Character Packing Engine

This engine moves characters between a character-wide device port and a table of 24-bit words in memory. It does this without using any program register. Each service request names the memory location of a 24-bit control word. The engine reads that word, transfers exactly one character, and writes the updated control word back to the same location. Because the whole transfer state lives in memory between requests, a driver only needs to set up the control word once and then let the device raise requests.

The control word holds four fields:

| Field | Bits | Meaning |
|---|---|---|
| N | 23..18 | Ones-complement count of the words still to move |
| C | 17..16 | Character counter |
| P | 15..14 | Packing mode |
| Y | 13..0 | Table address minus one |

The packing mode sets how many characters share one word:

| P | Characters per word | Character width |
|---|---|---|
| 00 | 4 | 6 bits |
| 01 | 3 | 8 bits |
| 10 | 2 | 12 bits |
| 11 | 1 | 24 bits |

Characters are taken most-significant first. In output direction the engine fetches the current table word and presents the selected character. In input direction the engine assembles characters in an internal register and stores the word only once it is complete. When the last word has been moved, the engine pulses an end-of-table interrupt.

Top module: `tio_pack_engine`

## Requirements
- R1: Each accepted request reads the control word at `req_cw_addr` and later writes the updated word back to the same address. When C is not 3, only C changes, and it increases by one.
- R2: When C is 3, the character just moved is the last one in its word. The written-back word then has C reloaded from P, N increased by one, and Y increased by one. The current table word address is always Y+1.
- R3: Packing mode P sets the characters per word and the character width: 00 gives four 6-bit characters, 01 gives three 8-bit, 10 gives two 12-bit, and 11 gives one 24-bit character. Character index C−P selects the character, with index 0 in the most-significant bits.
- R4: In output direction (`req_out`=1) the engine reads the table word. It then shows the selected character, zero-extended, on `dev_out_char` with `dev_out_vld` high for one cycle. `gnt` follows in the next cycle.
- R5: In input direction only the low character-width bits of `dev_in_char` are used. A table word is written to memory only by the request that supplies its last character, and that write holds all characters of the word.
- R6: `echo` is high for exactly one cycle, together with `gnt`, on the request after which N becomes all ones.
- R7: A request whose control word already has N all ones is granted with no memory write, no `dev_out_vld`, and no `echo`.
- R8: Each request produces exactly one single-cycle `gnt` pulse. `mem_re` and `mem_we` are never high together. After reset, `gnt`, `echo`, `mem_re`, `mem_we` and `dev_out_vld` are low.
- R9: The table address Y+1 and the increment of Y wrap modulo 2^14, so Y = 3FFF addresses word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Service request, sampled while idle |
| req_out | input | 1 | Direction of the request: 1 = memory to device, 0 = device to memory |
| req_cw_addr | input | 14 | Memory address of the control word |
| dev_in_char | input | 24 | Input character, right-aligned |
| gnt | output | 1 | One-cycle pulse when the request has been serviced |
| echo | output | 1 | One-cycle pulse when the table is finished |
| dev_out_char | output | 24 | Output character, right-aligned and zero-extended |
| dev_out_vld | output | 1 | Marks `dev_out_char` as valid |
| mem_addr | output | 14 | Memory address |
| mem_re | output | 1 | Memory read; data is returned on the next cycle |
| mem_we | output | 1 | Memory write |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data |

## Verification
The bench targets the word boundary in all four packing modes, for both directions. A design that mishandles the boundary leaves C, N or Y wrong in the written-back control word, or fetches characters from the wrong word.

It places junk in the unused high bits of input characters. It also checks the table word in memory after a non-final character, to catch a design that stores partial words or leaks upper bits.

It starts a table with Y = 3FFF, to catch a missing address wrap. It repeats a request after the table is finished, to catch a design that keeps writing or raises `echo` again.

// File: rtl/tio_pkg.sv
package tio_pkg;

    localparam int WORD_W = 24;
    localparam int N_W    = 6;
    localparam int C_W    = 2;
    localparam int P_W    = 2;
    localparam int Y_W    = 14;
    localparam int N_MODES = 1 << P_W;

    typedef enum logic [P_W-1:0] {
        PK_6  = 2'b00,
        PK_8  = 2'b01,
        PK_12 = 2'b10,
        PK_24 = 2'b11
    } pack_e;

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [C_W-1:0] c;
        pack_e          p;
        logic [Y_W-1:0] y;
    } cw_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CWRD,
        S_CWCAP,
        S_WRD,
        S_WCAP,
        S_PACK,
        S_WWR,
        S_CWWR,
        S_FIN
    } state_e;

    function automatic int mode_width(int m);
        case (m)
            0:       return 6;
            1:       return 8;
            2:       return 12;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/tio_cw_step.sv
module tio_cw_step
    import tio_pkg::*;
(
    input  cw_t             cur,
    output cw_t             nxt,
    output logic [Y_W-1:0]  word_addr,
    output logic [C_W-1:0]  char_idx,
    output logic            last_char,
    output logic            fin_now
);
    logic [N_W-1:0] n_inc;

    always_comb begin
        word_addr = cur.y + Y_W'(1);
        char_idx  = cur.c - C_W'(cur.p);
        last_char = &cur.c;
        n_inc     = cur.n + N_W'(1);
        fin_now   = last_char && (&n_inc);

        nxt   = cur;
        nxt.c = cur.c + C_W'(1);
        if (last_char) begin
            nxt.c = C_W'(cur.p);
            nxt.n = n_inc;
            nxt.y = word_addr;
        end
    end

endmodule

// File: rtl/tio_char_lane.sv
module tio_char_lane
    import tio_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  pack_e           mode,
    input  logic [C_W-1:0]  idx,
    input  logic [W-1:0]    word_in,
    input  logic [W-1:0]    asm_in,
    input  logic [W-1:0]    char_in,
    output logic [W-1:0]    char_out,
    output logic [W-1:0]    asm_out
);
    logic [W-1:0] ext_v [N_MODES];
    logic [W-1:0] ins_v [N_MODES];

    for (genvar m = 0; m < N_MODES; m++) begin : g_mode
        localparam int CHW = mode_width(m);
        localparam logic [W-1:0] MASK = W'((64'd1 << CHW) - 64'd1);
        int           sh;
        logic [W-1:0] base;

        always_comb begin
            sh = W - (int'(idx) + 1) * CHW;
            if (sh < 0) sh = 0;
            base = (idx == '0) ? '0 : asm_in;
            ext_v[m] = (word_in >> sh) & MASK;
            ins_v[m] = (base & ~(MASK << sh)) | ((char_in & MASK) << sh);
        end
    end

    assign char_out = ext_v[mode];
    assign asm_out  = ins_v[mode];

endmodule

// File: rtl/tio_asm_reg.sv
module tio_asm_reg
    import tio_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/tio_pack_engine.sv
module tio_pack_engine
    import tio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_out,
    input  logic [Y_W-1:0]    req_cw_addr,
    input  logic [WORD_W-1:0] dev_in_char,
    output logic              gnt,
    output logic              echo,
    output logic [WORD_W-1:0] dev_out_char,
    output logic              dev_out_vld,
    output logic [Y_W-1:0]    mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    state_e            state_q, state_d;
    cw_t               cw_q;
    cw_t               cw_nxt;
    logic              dir_out_q;
    logic [Y_W-1:0]    cw_addr_q;
    logic [WORD_W-1:0] char_q;
    logic [Y_W-1:0]    word_addr;
    logic [C_W-1:0]    char_idx;
    logic              last_char;
    logic              fin_now;
    logic [WORD_W-1:0] asm_q, asm_d;
    logic [WORD_W-1:0] ext_char;
    cw_t               cw_rd;

    assign cw_rd = cw_t'(mem_rdata);

    tio_cw_step u_step (
        .cur       (cw_q),
        .nxt       (cw_nxt),
        .word_addr (word_addr),
        .char_idx  (char_idx),
        .last_char (last_char),
        .fin_now   (fin_now)
    );

    tio_char_lane #(.W(WORD_W)) u_lane (
        .mode     (cw_q.p),
        .idx      (char_idx),
        .word_in  (mem_rdata),
        .asm_in   (asm_q),
        .char_in  (char_q),
        .char_out (ext_char),
        .asm_out  (asm_d)
    );

    tio_asm_reg #(.W(WORD_W)) u_asm (
        .clk  (clk),
        .rst  (rst),
        .load (state_q == S_PACK),
        .d    (asm_d),
        .q    (asm_q)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:  if (req) state_d = S_CWRD;
            S_CWRD:  state_d = S_CWCAP;
            S_CWCAP: begin
                if (&cw_rd.n)       state_d = S_FIN;
                else if (dir_out_q) state_d = S_WRD;
                else                state_d = S_PACK;
            end
            S_WRD:   state_d = S_WCAP;
            S_WCAP:  state_d = S_CWWR;
            S_PACK:  state_d = last_char ? S_WWR : S_CWWR;
            S_WWR:   state_d = S_CWWR;
            S_CWWR:  state_d = S_IDLE;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            cw_q      <= '0;
            dir_out_q <= 1'b0;
            cw_addr_q <= '0;
            char_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req) begin
                dir_out_q <= req_out;
                cw_addr_q <= req_cw_addr;
                char_q    <= dev_in_char;
            end
            if (state_q == S_CWCAP) cw_q <= cw_rd;
        end
    end

    always_comb begin
        mem_addr     = '0;
        mem_re       = 1'b0;
        mem_we       = 1'b0;
        mem_wdata    = '0;
        gnt          = 1'b0;
        echo         = 1'b0;
        dev_out_vld  = 1'b0;
        dev_out_char = '0;
        case (state_q)
            S_CWRD: begin
                mem_re   = 1'b1;
                mem_addr = cw_addr_q;
            end
            S_WRD: begin
                mem_re   = 1'b1;
                mem_addr = word_addr;
            end
            S_WCAP: begin
                dev_out_vld  = 1'b1;
                dev_out_char = ext_char;
            end
            S_WWR: begin
                mem_we    = 1'b1;
                mem_addr  = word_addr;
                mem_wdata = asm_q;
            end
            S_CWWR: begin
                mem_we    = 1'b1;
                mem_addr  = cw_addr_q;
                mem_wdata = cw_nxt;
                gnt       = 1'b1;
                echo      = fin_now;
            end
            S_FIN: gnt = 1'b1;
            default: ;
        endcase
    end

    AST_GNT_PULSE: assert property (@(posedge clk) disable iff (rst)
        gnt |=> !gnt) else $error("gnt longer than one cycle"); // R8

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)) else $error("read and write together"); // R8

    AST_ECHO_WITH_GNT: assert property (@(posedge clk) disable iff (rst)
        echo |-> gnt) else $error("echo without grant"); // R6

    AST_OUT_THEN_GNT: assert property (@(posedge clk) disable iff (rst)
        dev_out_vld |=> gnt) else $error("output char not followed by grant"); // R4

    AST_WORD_WR_LAST: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WWR) |-> last_char) else $error("partial word written"); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (gnt && !mem_we) |-> !echo) else $error("echo on finished table"); // R7

endmodule

// File: tb/tb_tio_pack_engine.sv
module tb_tio_pack_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_out = 1'b0;
    logic [13:0] req_cw_addr = '0;
    logic [23:0] dev_in_char = '0;
    logic        gnt, echo, dev_out_vld, mem_re, mem_we;
    logic [23:0] dev_out_char, mem_wdata;
    logic [23:0] mem_rdata = '0;
    logic [13:0] mem_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int wr_cnt = 0;

    logic [23:0] mem [0:1023];
    logic        tb_we = 1'b0;
    logic [9:0]  tb_addr = '0;
    logic [23:0] tb_data = '0;

    always #2.5 clk = ~clk;

    tio_pack_engine dut (
        .clk(clk), .rst(rst), .req(req), .req_out(req_out),
        .req_cw_addr(req_cw_addr), .dev_in_char(dev_in_char),
        .gnt(gnt), .echo(echo), .dev_out_char(dev_out_char),
        .dev_out_vld(dev_out_vld), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (tb_we) mem[tb_addr] <= tb_data;
    end

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog: run did not end, actual hung, expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [23:0] act,
                         input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [23:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = 10'(a); tb_data = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic logic [23:0] mk_cw(input logic [5:0] n, input logic [1:0] c,
                                         input logic [1:0] p, input logic [13:0] y);
        return {n, c, p, y};
    endfunction

    logic        r_vld, r_echo;
    logic [23:0] r_char;

    task automatic do_req(input bit dir, input int cwa, input logic [23:0] ch);
        int n;
        r_vld = 0; r_echo = 0; r_char = '0;
        @(negedge clk);
        req = 1'b1; req_out = dir; req_cw_addr = 14'(cwa); dev_in_char = ch;
        @(negedge clk);
        req = 1'b0;
        n = 0;
        while (!gnt && n < 20) begin
            if (dev_out_vld) begin r_vld = 1; r_char = dev_out_char; end
            @(negedge clk);
            n++;
        end
        r_echo = echo;
        check(gnt == 1'b1, "R8 grant seen", 24'(gnt), 24'd1);
        @(negedge clk);
        check(gnt == 1'b0, "R8 grant single cycle", 24'(gnt), 24'd0);
    endtask

    task automatic t_reset;
        check(gnt == 0 && echo == 0 && mem_re == 0 && mem_we == 0 && dev_out_vld == 0,
              "R8 reset outputs", {19'd0, gnt, echo, mem_re, mem_we, dev_out_vld}, 24'd0);
    endtask

    task automatic t_out8;
        logic [23:0] exp [6];
        exp = '{24'hA1, 24'hB2, 24'hC3, 24'h44, 24'h55, 24'h66};
        poke(16, 24'hA1B2C3);
        poke(17, 24'h445566);
        poke(256, mk_cw(~6'd2, 2'b01, 2'b01, 14'd15));
        for (int i = 0; i < 6; i++) begin
            do_req(1'b1, 256, '0);
            check(r_vld && r_char == exp[i], "R3 R4 8-bit output char", r_char, exp[i]);
            check(r_echo == (i == 5), "R6 echo only on last", 24'(r_echo), 24'(i == 5));
            if (i == 0)
                check(mem[256] == mk_cw(~6'd2, 2'b10, 2'b01, 14'd15), "R1 C increments",
                      mem[256], mk_cw(~6'd2, 2'b10, 2'b01, 14'd15));
            if (i == 2)
                check(mem[256] == mk_cw(~6'd1, 2'b01, 2'b01, 14'd16), "R2 word boundary",
                      mem[256], mk_cw(~6'd1, 2'b01, 2'b01, 14'd16));
        end
        check(mem[256] == mk_cw(6'h3F, 2'b01, 2'b01, 14'd17), "R2 final control word",
              mem[256], mk_cw(6'h3F, 2'b01, 2'b01, 14'd17));
    endtask

    task automatic t_out6_wrap;
        logic [23:0] exp [4];
        exp = '{24'h04, 24'h23, 24'h11, 24'h16};
        poke(0, 24'h123456);
        poke(257, mk_cw(~6'd1, 2'b00, 2'b00, 14'h3FFF));
        for (int i = 0; i < 4; i++) begin
            do_req(1'b1, 257, '0);
            check(r_vld && r_char == exp[i], "R9 R3 6-bit char at wrapped address", r_char, exp[i]);
            check(r_echo == (i == 3), "R6 echo 6-bit", 24'(r_echo), 24'(i == 3));
        end
        check(mem[257] == mk_cw(6'h3F, 2'b00, 2'b00, 14'd0), "R9 Y wraps to zero",
              mem[257], mk_cw(6'h3F, 2'b00, 2'b00, 14'd0));
    endtask

    task automatic t_in12;
        logic [23:0] ch [4];
        ch = '{24'hABC, 24'h123, 24'hFED, 24'h0F0};
        poke(32, 24'h5A5A5A);
        poke(33, 24'h5A5A5A);
        poke(258, mk_cw(~6'd2, 2'b10, 2'b10, 14'd31));
        for (int i = 0; i < 4; i++) begin
            do_req(1'b0, 258, ch[i]);
            check(r_vld == 0, "R4 no output char on input", 24'(r_vld), 24'd0);
            if (i == 0)
                check(mem[32] == 24'h5A5A5A, "R5 no write before last char", mem[32], 24'h5A5A5A);
            if (i == 1)
                check(mem[32] == 24'hABC123, "R5 R3 12-bit word packed", mem[32], 24'hABC123);
            check(r_echo == (i == 3), "R6 echo input", 24'(r_echo), 24'(i == 3));
        end
        check(mem[33] == 24'hFED0F0, "R5 second 12-bit word", mem[33], 24'hFED0F0);
    endtask

    task automatic t_in6_junk;
        logic [5:0] v [4];
        v = '{6'h3F, 6'h00, 6'h2A, 6'h15};
        poke(40, 24'h000000);
        poke(259, mk_cw(~6'd1, 2'b00, 2'b00, 14'd39));
        for (int i = 0; i < 4; i++)
            do_req(1'b0, 259, 24'hABCDC0 | {18'd0, v[i]});
        check(mem[40] == 24'hFC0A95, "R5 upper input bits ignored", mem[40], 24'hFC0A95);
    endtask

    task automatic t_in24_then_done;
        int w0;
        logic [23:0] cw_done;
        poke(260, mk_cw(~6'd2, 2'b11, 2'b11, 14'd47));
        do_req(1'b0, 260, 24'h123456);
        check(mem[48] == 24'h123456, "R3 R5 24-bit word stored", mem[48], 24'h123456);
        check(r_echo == 0, "R6 no early echo 24-bit", 24'(r_echo), 24'd0);
        do_req(1'b0, 260, 24'hFEDCBA);
        check(mem[49] == 24'hFEDCBA, "R5 second 24-bit word", mem[49], 24'hFEDCBA);
        check(r_echo == 1, "R6 echo 24-bit", 24'(r_echo), 24'd1);
        cw_done = mem[260];
        w0 = wr_cnt;
        do_req(1'b0, 260, 24'h777777);
        check(wr_cnt == w0, "R7 no write after finish", 24'(wr_cnt), 24'(w0));
        check(r_echo == 0, "R7 no echo after finish", 24'(r_echo), 24'd0);
        do_req(1'b1, 260, '0);
        check(r_vld == 0 && wr_cnt == w0, "R7 no output after finish", 24'(r_vld), 24'd0);
        check(mem[260] == cw_done && mem[50] !== 24'h777777, "R7 state unchanged",
              mem[260], cw_done);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_out8();
        t_out6_wrap();
        t_in12();
        t_in6_junk();
        t_in24_then_done();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule